// File: doc/BRIEF.md
# Steering Target Resolver

This block takes the address offset of a replicated register and works out a group/instance pair that steers a read to a copy of that register that is present and powered. Every steering kind owns a few inclusive address windows. The block checks these kinds in a fixed order. The first kind whose window contains the offset picks the rule that turns the fuse-derived availability masks into a target. If no window matches, the block returns a default pair that the caller supplies.

The caller pulses a request with the offset and the current masks. One cycle later the block presents the registered target, the code of the kind that matched and an error flag, together with a one-cycle valid strobe. The window tables are parameters. Nothing in the block is programmable at run time.

Top module: `steer_target_resolver`

## Requirements
- R1: An offset matches a window when lo <= offset <= hi, with both ends included. The default windows are:
  - bank: 0x1100-0x13FF
  - memory slice: 0x2000-0x20FF and 0x3000-0x37FF
  - cache node: 0x1000-0x10FF and 0x2800-0x28FF
  - subslice: 0x5000-0x5FFF and 0x6100-0x613F
  - origin: 0x4000-0x4AFF and 0x1080-0x10FF
- R2: Kinds are checked in a fixed order: bank (code 0), memory slice (1), cache node (2), subslice (3), origin (4). The lowest code that matches is reported on `kind_o`.
- R3: When no window matches, `kind_o` is 5, `err_o` is 0, and group/instance equal the default inputs.
- R4: Bank kind. Bit g of the 3-bit bank fuse enables banks 2g and 2g+1. The instance is the index of the lowest enabled bank, and the group is 0.
- R5: Memory-slice kind. Slice s counts as available if its memory-enable bit is set, or if any of subslices 4s..4s+3 is enabled. The group is the lowest available slice, and the instance is 0.
- R6: Cache-node kind. The group is twice the lowest available slice (using the R5 rule), and the instance is 0.
- R7: Subslice kind. With n the lowest enabled subslice, the group is n/4 and the instance is n mod 4.
- R8: Origin kind. The target is always group 0, instance 0.
- R9: If the mask that a matched kind needs has no set bit, `err_o` is 1 and the target is group 0, instance 0.
- R10: `vld_o` is high exactly in the cycle after a cycle with `req_i` high. Outputs hold their values while no request is taken.
- R11: After reset, `vld_o`, `err_o`, `group_o`, `inst_o` and `kind_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Resolve request strobe |
| offset_i | input | AW (24) | Register offset to resolve |
| bank_fuse_i | input | BANK_GRPS (3) | Bank-pair enable fuse field |
| slice_mem_en_i | input | NSLICE (4) | Per-slice memory enable |
| subslice_en_i | input | NSLICE*SS_PER_SLICE (16) | Subslice enable mask |
| dflt_group_i | input | GW (4) | Default group when no window matches |
| dflt_inst_i | input | IW (4) | Default instance when no window matches |
| vld_o | output | 1 | Result valid strobe |
| group_o | output | GW (4) | Resolved group |
| inst_o | output | IW (4) | Resolved instance |
| kind_o | output | 3 | Matched kind code (5 = none) |
| err_o | output | 1 | Required mask was empty |

## Verification
The assertions check the following on every cycle:
- the request-to-valid timing and that results hold between requests;
- the zero target on errors and on origin matches;
- the even group of node matches;
- that the default result never carries an error.

Only the bench scenarios can show:
- that windows are inclusive at both ends;
- that the lower code wins where windows overlap;
- the find-first-set, doubling and divide/modulo rules against actual fuse patterns, including slice availability that comes only from subslices.

// File: rtl/steer_pkg.sv
package steer_pkg;
   typedef enum logic [2:0] {
      ST_BANK   = 3'd0,
      ST_MSLICE = 3'd1,
      ST_NODE   = 3'd2,
      ST_SUBSL  = 3'd3,
      ST_INST0  = 3'd4,
      ST_DFLT   = 3'd5
   } steer_kind_e;

   localparam int NUM_KINDS = 5;
endpackage

// File: rtl/steer_range_hit.sv
module steer_range_hit #(
   parameter int AW = 24,
   parameter int NR = 2,
   parameter logic [NR*AW-1:0] LO = '0,
   parameter logic [NR*AW-1:0] HI = '0
) (
   input  logic [AW-1:0] offset_i,
   output logic          hit_o
);
   logic [NR-1:0] win_hit;

   for (genvar r = 0; r < NR; r++) begin : g_win
      // a window with lo > hi is unused and can never match
      assign win_hit[r] = (offset_i >= LO[r*AW +: AW]) && (offset_i <= HI[r*AW +: AW]);
   end

   assign hit_o = |win_hit;
endmodule

// File: rtl/steer_ffs.sv
module steer_ffs #(
   parameter int W = 8,
   localparam int IDXW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]    vec_i,
   output logic [IDXW-1:0] idx_o,
   output logic            any_o
);
   always_comb begin
      idx_o = '0;
      for (int b = W - 1; b >= 0; b--) begin
         if (vec_i[b]) idx_o = IDXW'(b);
      end
   end

   assign any_o = |vec_i;

   always_comb begin
      if (any_o) begin
         AST_FFS_HIT: assert (vec_i[idx_o]) else $error("ffs index not set"); // R4
      end
   end
endmodule

// File: rtl/steer_avail.sv
module steer_avail #(
   parameter int BANK_GRPS     = 3,
   parameter int BANKS_PER_GRP = 2,
   parameter int NSLICE        = 4,
   parameter int SS_PER_SLICE  = 4,
   localparam int NBANK = BANK_GRPS * BANKS_PER_GRP,
   localparam int NSS   = NSLICE * SS_PER_SLICE
) (
   input  logic [BANK_GRPS-1:0] bank_fuse_i,
   input  logic [NSLICE-1:0]    slice_mem_en_i,
   input  logic [NSS-1:0]       subslice_en_i,
   output logic [NBANK-1:0]     bank_mask_o,
   output logic [NSLICE-1:0]    slice_avail_o
);
   for (genvar g = 0; g < BANK_GRPS; g++) begin : g_bgrp
      for (genvar b = 0; b < BANKS_PER_GRP; b++) begin : g_bank
         assign bank_mask_o[g*BANKS_PER_GRP + b] = bank_fuse_i[g];
      end
   end

   for (genvar s = 0; s < NSLICE; s++) begin : g_slice
      assign slice_avail_o[s] = slice_mem_en_i[s] | (|subslice_en_i[s*SS_PER_SLICE +: SS_PER_SLICE]);
   end
endmodule

// File: rtl/steer_target_resolver.sv
module steer_target_resolver
   import steer_pkg::*;
#(
   parameter int AW            = 24,
   parameter int GW            = 4,
   parameter int IW            = 4,
   parameter int NR            = 2,
   parameter int BANK_GRPS     = 3,
   parameter int BANKS_PER_GRP = 2,
   parameter int NSLICE        = 4,
   parameter int SS_PER_SLICE  = 4,
   parameter logic [NR*AW-1:0] BANK_LO   = {24'hFFFFFF, 24'h001100},
   parameter logic [NR*AW-1:0] BANK_HI   = {24'h000000, 24'h0013FF},
   parameter logic [NR*AW-1:0] MSLICE_LO = {24'h003000, 24'h002000},
   parameter logic [NR*AW-1:0] MSLICE_HI = {24'h0037FF, 24'h0020FF},
   parameter logic [NR*AW-1:0] NODE_LO   = {24'h002800, 24'h001000},
   parameter logic [NR*AW-1:0] NODE_HI   = {24'h0028FF, 24'h0010FF},
   parameter logic [NR*AW-1:0] SUBSL_LO  = {24'h006100, 24'h005000},
   parameter logic [NR*AW-1:0] SUBSL_HI  = {24'h00613F, 24'h005FFF},
   parameter logic [NR*AW-1:0] INST0_LO  = {24'h001080, 24'h004000},
   parameter logic [NR*AW-1:0] INST0_HI  = {24'h0010FF, 24'h004AFF},
   localparam int NBANK = BANK_GRPS * BANKS_PER_GRP,
   localparam int NSS   = NSLICE * SS_PER_SLICE,
   localparam int BIW   = (NBANK > 1) ? $clog2(NBANK) : 1,
   localparam int SIW   = (NSLICE > 1) ? $clog2(NSLICE) : 1,
   localparam int SSIW  = (NSS > 1) ? $clog2(NSS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_i,
   input  logic [AW-1:0]        offset_i,
   input  logic [BANK_GRPS-1:0] bank_fuse_i,
   input  logic [NSLICE-1:0]    slice_mem_en_i,
   input  logic [NSS-1:0]       subslice_en_i,
   input  logic [GW-1:0]        dflt_group_i,
   input  logic [IW-1:0]        dflt_inst_i,
   output logic                 vld_o,
   output logic [GW-1:0]        group_o,
   output logic [IW-1:0]        inst_o,
   output logic [2:0]           kind_o,
   output logic                 err_o
);
   // elaboration-time parameter checks
   if (2**GW <= 2*(NSLICE-1)) begin : g_bad_gw_node
      $error("GW too narrow for node group");
   end
   if (2**GW < NSLICE) begin : g_bad_gw_ss
      $error("GW too narrow for subslice group");
   end
   if (2**IW < NBANK) begin : g_bad_iw_bank
      $error("IW too narrow for bank index");
   end
   if (2**IW < SS_PER_SLICE) begin : g_bad_iw_ss
      $error("IW too narrow for subslice instance");
   end

   localparam logic [NUM_KINDS-1:0][NR*AW-1:0] LO_TAB = {INST0_LO, SUBSL_LO, NODE_LO, MSLICE_LO, BANK_LO};
   localparam logic [NUM_KINDS-1:0][NR*AW-1:0] HI_TAB = {INST0_HI, SUBSL_HI, NODE_HI, MSLICE_HI, BANK_HI};

   logic [NUM_KINDS-1:0] kind_hit;

   for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
      steer_range_hit #(
         .AW(AW), .NR(NR), .LO(LO_TAB[k]), .HI(HI_TAB[k])
      ) u_hit (
         .offset_i (offset_i),
         .hit_o    (kind_hit[k])
      );
   end

   logic [NBANK-1:0]  bank_mask;
   logic [NSLICE-1:0] slice_avail;

   steer_avail #(
      .BANK_GRPS(BANK_GRPS), .BANKS_PER_GRP(BANKS_PER_GRP),
      .NSLICE(NSLICE), .SS_PER_SLICE(SS_PER_SLICE)
   ) u_avail (
      .bank_fuse_i    (bank_fuse_i),
      .slice_mem_en_i (slice_mem_en_i),
      .subslice_en_i  (subslice_en_i),
      .bank_mask_o    (bank_mask),
      .slice_avail_o  (slice_avail)
   );

   logic [BIW-1:0]  bank_idx;
   logic [SIW-1:0]  slice_idx;
   logic [SSIW-1:0] ss_idx;
   logic            bank_any, slice_any, ss_any;

   steer_ffs #(.W(NBANK))  u_ffs_bank  (.vec_i(bank_mask),     .idx_o(bank_idx),  .any_o(bank_any));
   steer_ffs #(.W(NSLICE)) u_ffs_slice (.vec_i(slice_avail),   .idx_o(slice_idx), .any_o(slice_any));
   steer_ffs #(.W(NSS))    u_ffs_ss    (.vec_i(subslice_en_i), .idx_o(ss_idx),    .any_o(ss_any));

   // first matching kind in fixed order wins
   steer_kind_e kind_d;
   always_comb begin
      kind_d = ST_DFLT;
      for (int k = NUM_KINDS - 1; k >= 0; k--) begin
         if (kind_hit[k]) kind_d = steer_kind_e'(3'(k));
      end
   end

   logic [GW-1:0] group_d;
   logic [IW-1:0] inst_d;
   logic          err_d;

   always_comb begin
      group_d = '0;
      inst_d  = '0;
      err_d   = 1'b0;
      unique case (kind_d)
         ST_BANK: begin
            err_d = !bank_any;
            if (bank_any) inst_d = IW'(bank_idx);
         end
         ST_MSLICE: begin
            err_d = !slice_any;
            if (slice_any) group_d = GW'(slice_idx);
         end
         ST_NODE: begin
            err_d = !slice_any;
            if (slice_any) group_d = GW'({slice_idx, 1'b0});
         end
         ST_SUBSL: begin
            err_d = !ss_any;
            if (ss_any) begin
               group_d = GW'(32'(ss_idx) / SS_PER_SLICE);
               inst_d  = IW'(32'(ss_idx) % SS_PER_SLICE);
            end
         end
         ST_INST0: begin
            group_d = '0;
            inst_d  = '0;
         end
         default: begin
            group_d = dflt_group_i;
            inst_d  = dflt_inst_i;
         end
      endcase
   end

   steer_kind_e kind_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o   <= 1'b0;
         group_o <= '0;
         inst_o  <= '0;
         kind_q  <= ST_BANK;
         err_o   <= 1'b0;
      end else begin
         vld_o <= req_i;
         if (req_i) begin
            group_o <= group_d;
            inst_o  <= inst_d;
            kind_q  <= kind_d;
            err_o   <= err_d;
         end
      end
   end

   assign kind_o = kind_q;

   AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_i |=> vld_o); // R10
   AST_NO_SPURIOUS_VLD: assert property (@(posedge clk) disable iff (!rst_n) !req_i |=> !vld_o); // R10
   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> ($stable(group_o) && $stable(inst_o) && $stable(kind_o) && $stable(err_o))); // R10
   AST_ERR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && err_o) |-> (group_o == '0 && inst_o == '0)); // R9
   AST_INST0_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && kind_o == ST_INST0) |-> (group_o == '0 && inst_o == '0)); // R8
   AST_DFLT_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && kind_o == ST_DFLT) |-> !err_o); // R3
   AST_NODE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && kind_o == ST_NODE) |-> (!group_o[0] && inst_o == '0)); // R6
endmodule

// File: tb/steer_target_resolver_tb.sv
module steer_target_resolver_tb;
   localparam int CLK_P = 10;
   localparam int NV    = 22;

   typedef struct packed {
      logic [23:0] off;
      logic [2:0]  fuse;
      logic [3:0]  mem;
      logic [15:0] ss;
      logic [3:0]  dg;
      logic [3:0]  di;
      logic [2:0]  kind;
      logic [3:0]  g;
      logic [3:0]  i;
      logic        err;
   } vec_t;

   // off, fuse, mem, ss, dflt g, dflt i, exp kind, exp g, exp i, exp err
   localparam vec_t VECS [NV] = '{
      '{24'h001200, 3'b010, 4'b0100, 16'h0300, 4'd9, 4'd5, 3'd0, 4'd0, 4'd2, 1'b0}, // R4
      '{24'h001100, 3'b001, 4'b0100, 16'h0300, 4'd9, 4'd5, 3'd0, 4'd0, 4'd0, 1'b0}, // R1 lo edge
      '{24'h0013FF, 3'b100, 4'b0100, 16'h0300, 4'd9, 4'd5, 3'd0, 4'd0, 4'd4, 1'b0}, // R1 hi edge
      '{24'h001400, 3'b010, 4'b0100, 16'h0300, 4'd9, 4'd5, 3'd5, 4'd9, 4'd5, 1'b0}, // R3
      '{24'h002000, 3'b010, 4'b0100, 16'h0300, 4'd9, 4'd5, 3'd1, 4'd2, 4'd0, 1'b0}, // R5
      '{24'h0037FF, 3'b010, 4'b0000, 16'h0030, 4'd9, 4'd5, 3'd1, 4'd1, 4'd0, 1'b0}, // R5
      '{24'h001000, 3'b010, 4'b0000, 16'h0030, 4'd9, 4'd5, 3'd2, 4'd2, 4'd0, 1'b0}, // R6
      '{24'h0028FF, 3'b010, 4'b1000, 16'h8000, 4'd9, 4'd5, 3'd2, 4'd6, 4'd0, 1'b0}, // R6
      '{24'h005000, 3'b010, 4'b0000, 16'h0300, 4'd9, 4'd5, 3'd3, 4'd2, 4'd0, 1'b0}, // R7
      '{24'h005FFF, 3'b010, 4'b0000, 16'h0080, 4'd9, 4'd5, 3'd3, 4'd1, 4'd3, 1'b0}, // R7
      '{24'h006100, 3'b010, 4'b0000, 16'h4000, 4'd9, 4'd5, 3'd3, 4'd3, 4'd2, 1'b0}, // R7
      '{24'h004000, 3'b010, 4'b0100, 16'h0300, 4'd9, 4'd5, 3'd4, 4'd0, 4'd0, 1'b0}, // R8
      '{24'h001090, 3'b010, 4'b0010, 16'h0000, 4'd9, 4'd5, 3'd2, 4'd2, 4'd0, 1'b0}, // R2
      '{24'h0010FF, 3'b010, 4'b0000, 16'h0000, 4'd9, 4'd5, 3'd2, 4'd0, 4'd0, 1'b1}, // R9
      '{24'h004AFF, 3'b010, 4'b0100, 16'h0300, 4'd9, 4'd5, 3'd4, 4'd0, 4'd0, 1'b0}, // R8
      '{24'h004B00, 3'b010, 4'b0100, 16'h0300, 4'd9, 4'd5, 3'd5, 4'd9, 4'd5, 1'b0}, // R3
      '{24'h001200, 3'b000, 4'b0100, 16'h0300, 4'd9, 4'd5, 3'd0, 4'd0, 4'd0, 1'b1}, // R9
      '{24'h005800, 3'b010, 4'b0100, 16'h0000, 4'd9, 4'd5, 3'd3, 4'd0, 4'd0, 1'b1}, // R9
      '{24'h003000, 3'b010, 4'b0000, 16'h0000, 4'd9, 4'd5, 3'd1, 4'd0, 4'd0, 1'b1}, // R9
      '{24'h002050, 3'b010, 4'b0010, 16'h0001, 4'd9, 4'd5, 3'd1, 4'd0, 4'd0, 1'b0}, // R5
      '{24'h000FFF, 3'b010, 4'b0000, 16'h0000, 4'd3, 4'd12, 3'd5, 4'd3, 4'd12, 1'b0}, // R3
      '{24'h006140, 3'b010, 4'b0000, 16'h4000, 4'd9, 4'd5, 3'd5, 4'd9, 4'd5, 1'b0}  // R1
   };

   localparam string TAGS [NV] = '{
      "R4", "R1", "R1", "R3", "R5", "R5", "R6", "R6", "R7", "R7", "R7",
      "R8", "R2", "R9", "R8", "R3", "R9", "R9", "R9", "R5", "R3", "R1"
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic [23:0] offset_i = '0;
   logic [2:0]  bank_fuse_i = '0;
   logic [3:0]  slice_mem_en_i = '0;
   logic [15:0] subslice_en_i = '0;
   logic [3:0]  dflt_group_i = '0;
   logic [3:0]  dflt_inst_i = '0;
   logic        vld_o;
   logic [3:0]  group_o;
   logic [3:0]  inst_o;
   logic [2:0]  kind_o;
   logic        err_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   steer_target_resolver u_dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .offset_i(offset_i),
      .bank_fuse_i(bank_fuse_i), .slice_mem_en_i(slice_mem_en_i),
      .subslice_en_i(subslice_en_i), .dflt_group_i(dflt_group_i),
      .dflt_inst_i(dflt_inst_i), .vld_o(vld_o), .group_o(group_o),
      .inst_o(inst_o), .kind_o(kind_o), .err_o(err_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      offset_i       = v.off;
      bank_fuse_i    = v.fuse;
      slice_mem_en_i = v.mem;
      subslice_en_i  = v.ss;
      dflt_group_i   = v.dg;
      dflt_inst_i    = v.di;
   endtask

   // packs {vld, kind, group, inst, err}
   function automatic logic [31:0] pack_exp(input vec_t v);
      return {19'd0, 1'b1, v.kind, v.g, v.i, v.err};
   endfunction

   function automatic logic [31:0] pack_act();
      return {19'd0, vld_o, kind_o, group_o, inst_o, err_o};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11", {19'd0, vld_o, kind_o, group_o, inst_o, err_o}, 32'd0);

      for (int k = 0; k < NV; k++) begin
         drive(VECS[k]);
         req_i = 1'b1;
         @(negedge clk);
         req_i = 1'b0;
         chk(TAGS[k], pack_act(), pack_exp(VECS[k]));
      end

      // R10: no request -> valid drops and result holds despite new inputs
      drive(VECS[0]);
      @(negedge clk);
      chk("R10", {31'd0, vld_o}, 32'd0);
      chk("R10", {24'd0, group_o, inst_o}, {24'd0, VECS[NV-1].g, VECS[NV-1].i});

      // R10: back-to-back requests give one result per cycle
      drive(VECS[6]);
      req_i = 1'b1;
      @(negedge clk);
      chk("R10", pack_act(), pack_exp(VECS[6]));
      drive(VECS[10]);
      @(negedge clk);
      req_i = 1'b0;
      chk("R10", pack_act(), pack_exp(VECS[10]));
      @(negedge clk);
      chk("R10", {31'd0, vld_o}, 32'd0);

      // R11: reset mid-run clears the result
      rst_n = 1'b0;
      @(negedge clk);
      chk("R11", {19'd0, vld_o, kind_o, group_o, inst_o, err_o}, 32'd0);
      rst_n = 1'b1;
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (5000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule